// File: doc/BRIEF.md
# Lane-and-rate capability negotiator

This block settles the operating mode of a serial link that can run at a base or a double data rate, over one or two lanes. It builds the local 8-bit capability message for the link partner, decodes the partner's message when it arrives, and picks a rate and a lane count. The block sees each dimension separately and takes the lower of the two sides in each one.

The exchange runs in the port-match step of link polling, after receiver equalization. The surrounding training logic reports each failed attempt at training with a one-cycle strobe. On that strobe the block moves to the next mode that both sides support, in a fixed fallback order. When no slower mode is left, it raises a give-up flag. When the resolved lane count is one, only lane 0 (the configuration lane) carries traffic.

Top module: `lane_rate_negotiator`

## Requirements
- R1: `tx_msg` carries the local double-rate capability in bit 2 and the local two-lane capability in bit 6. Bits 0, 1, 3, 4, 5 and 7 are always zero.
- R2: In a received message, the rate field is bits [3:2], where 2'b01 means double rate. The value 2'b00, and the reserved values 2'b10 and 2'b11, all mean base rate. Bit 6 set means two lanes. All other received bits are ignored.
- R3: After an exchange, `mode_fast` is 1 only when both the local side and the partner support double rate.
- R4: After an exchange, `mode_two_lane` is 1 only when both sides support two lanes. A single-lane fast side paired with a two-lane slow side resolves to one lane at base rate.
- R5: A message accepted on `rx_valid` updates the mode outputs and sets `done` on the next clock edge. It also clears `give_up`.
- R6: With `done` set and no message present, each `train_fail` strobe moves down the order 2-lane fast, 1-lane fast, 2-lane slow, 1-lane slow. Any mode that is not common to both sides is skipped.
- R7: A `train_fail` strobe at 1-lane slow sets `give_up` and leaves the mode unchanged.
- R8: `train_fail` has no effect before the first exchange. When `train_fail` and `rx_valid` arrive in the same cycle, the message wins.
- R9: Reset clears `mode_fast`, `mode_two_lane`, `done` and `give_up`. Without a message or a failure strobe, these outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_fast_ok | input | 1 | Local side supports double rate |
| loc_two_lane_ok | input | 1 | Local side supports two lanes |
| rx_valid | input | 1 | Partner capability message present this cycle |
| rx_msg | input | 8 | Partner capability message |
| train_fail | input | 1 | Training at the current mode failed (one-cycle strobe) |
| tx_msg | output | 8 | Local capability message |
| mode_fast | output | 1 | Resolved rate: 1 double, 0 base |
| mode_two_lane | output | 1 | Resolved lanes: 1 two lanes, 0 lane 0 only |
| done | output | 1 | A mode has been resolved |
| give_up | output | 1 | Fallback exhausted at 1-lane slow |

## Verification
The bench sends received bytes that carry the reserved rate codes and junk in the ignored bits. A decoder that reads only bit 2, or reads the whole byte, would then report double rate or fail to match the model. The bench sends mixed pairs, one lane fast against two lanes slow, where a design that picks a "best" mode would keep a lane or the fast rate that one side lacks. It walks complete fallback chains with different common capabilities. A sequencer that skips no unsupported mode would try 2-lane slow without common two-lane support, and one that wraps would leave 1-lane slow instead of giving up. The bench also sends failure strobes before any exchange and in the same cycle as a message, which catches a wrong priority.

// File: rtl/negotiator_pkg.sv
// Package: shared mode encoding for the capability negotiator.
// The mode codes follow the fallback order, so a larger code is a slower mode.
package negotiator_pkg;
    localparam int MSG_W = 8;
    localparam int RATE_LSB = 2;
    localparam int LANE_BIT = 6;

    typedef enum logic [1:0] {
        MODE_X2_FAST = 2'd0,
        MODE_X1_FAST = 2'd1,
        MODE_X2_SLOW = 2'd2,
        MODE_X1_SLOW = 2'd3
    } mode_e;
endpackage

// File: rtl/cap_msg_builder.sv
// Module: cap_msg_builder
// Builds the outgoing capability byte from the local capability inputs.
// Assumes: every bit that is neither the rate field nor the lane bit is sent as zero.
module cap_msg_builder
    import negotiator_pkg::*;
(
    input  logic             fast_ok,
    input  logic             two_ok,
    output logic [MSG_W-1:0] msg
);
    // Places the rate field (2'b01 = double rate) and the lane bit.
    always_comb begin
        msg = '0;
        msg[RATE_LSB+1 -: 2] = {1'b0, fast_ok};
        msg[LANE_BIT] = two_ok;
    end
endmodule

// File: rtl/cap_msg_parser.sv
// Module: cap_msg_parser
// Decodes a partner capability byte into rate and lane capability.
// Assumes: the reserved rate codes are read as base rate; all other bits are ignored.
module cap_msg_parser
    import negotiator_pkg::*;
(
    input  logic [MSG_W-1:0] msg,
    output logic             peer_fast,
    output logic             peer_two
);
    // Only the exact code 2'b01 means double rate.
    always_comb begin
        peer_fast = (msg[RATE_LSB+1 -: 2] == 2'b01);
        peer_two  = msg[LANE_BIT];
    end
endmodule

// File: rtl/fallback_sequencer.sv
// Module: fallback_sequencer
// Holds the common capabilities and the current mode. It resolves a new mode on
// each exchange and steps down the fallback order on each failure strobe.
// Assumes: an exchange takes priority over a failure strobe in the same cycle.
module fallback_sequencer
    import negotiator_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loc_fast,
    input  logic loc_two,
    input  logic peer_fast,
    input  logic peer_two,
    input  logic xchg,
    input  logic fail,
    output logic mode_fast,
    output logic mode_two,
    output logic done,
    output logic give_up
);
    mode_e mode_q, mode_res, mode_nxt;
    logic  cfast_q, ctwo_q, done_q, give_q;
    logic  cfast_d, ctwo_d;

    // Common capability of this exchange: the lower side wins in each dimension.
    always_comb begin
        cfast_d = loc_fast & peer_fast;
        ctwo_d  = loc_two & peer_two;
    end

    // Fastest mode that both sides support.
    always_comb begin
        if (cfast_d && ctwo_d)  mode_res = MODE_X2_FAST;
        else if (cfast_d)       mode_res = MODE_X1_FAST;
        else if (ctwo_d)        mode_res = MODE_X2_SLOW;
        else                    mode_res = MODE_X1_SLOW;
    end

    // Next supported mode below the current one in the fallback order.
    always_comb begin
        case (mode_q)
            MODE_X2_FAST: mode_nxt = cfast_q ? MODE_X1_FAST
                                   : (ctwo_q ? MODE_X2_SLOW : MODE_X1_SLOW);
            MODE_X1_FAST: mode_nxt = ctwo_q ? MODE_X2_SLOW : MODE_X1_SLOW;
            default:      mode_nxt = MODE_X1_SLOW;
        endcase
    end

    // State update: reset, then exchange, then failure strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_X1_SLOW;
            cfast_q <= 1'b0;
            ctwo_q  <= 1'b0;
            done_q  <= 1'b0;
            give_q  <= 1'b0;
        end else if (xchg) begin
            mode_q  <= mode_res;
            cfast_q <= cfast_d;
            ctwo_q  <= ctwo_d;
            done_q  <= 1'b1;
            give_q  <= 1'b0;
        end else if (fail && done_q) begin
            if (mode_q == MODE_X1_SLOW) give_q <= 1'b1;
            else                        mode_q <= mode_nxt;
        end
    end

    // Decodes the mode register to the rate and lane outputs.
    always_comb begin
        mode_fast = (mode_q == MODE_X2_FAST) || (mode_q == MODE_X1_FAST);
        mode_two  = (mode_q == MODE_X2_FAST) || (mode_q == MODE_X2_SLOW);
        done      = done_q;
        give_up   = give_q;
    end

    // R3: without double-rate support on one side, the resolved rate is base
    a_r3_rate_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg && !(loc_fast && peer_fast)) |=> !mode_fast);

    // R4: without two-lane support on one side, only lane 0 is used
    a_r4_lane_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg && !(loc_two && peer_two)) |=> !mode_two);

    // R6: a failure above the slowest mode changes the mode
    a_r6_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !xchg && done && (mode_fast || mode_two)) |=> !$stable({mode_fast, mode_two}));

    // R7: give-up is only held at 1-lane slow
    a_r7_giveup_slowest: assert property (@(posedge clk) disable iff (!rst_n)
        give_up |-> (!mode_fast && !mode_two && done));

    // R9: with no message and no failure strobe, the outputs hold
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xchg && !fail) |=> $stable({mode_fast, mode_two, done, give_up}));
endmodule

// File: rtl/lane_rate_negotiator.sv
// Module: lane_rate_negotiator (top)
// Runs the capability exchange: it builds the local byte, decodes the partner
// byte, and resolves and falls back the operating rate and lane count.
// Assumes: rx_valid and train_fail are single-cycle strobes in the clk domain.
module lane_rate_negotiator
    import negotiator_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_fast_ok,
    input  logic             loc_two_lane_ok,
    input  logic             rx_valid,
    input  logic [MSG_W-1:0] rx_msg,
    input  logic             train_fail,
    output logic [MSG_W-1:0] tx_msg,
    output logic             mode_fast,
    output logic             mode_two_lane,
    output logic             done,
    output logic             give_up
);
    logic peer_fast, peer_two;

    cap_msg_builder u_build (
        .fast_ok (loc_fast_ok),
        .two_ok  (loc_two_lane_ok),
        .msg     (tx_msg)
    );

    cap_msg_parser u_parse (
        .msg       (rx_msg),
        .peer_fast (peer_fast),
        .peer_two  (peer_two)
    );

    fallback_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_fast  (loc_fast_ok),
        .loc_two   (loc_two_lane_ok),
        .peer_fast (peer_fast),
        .peer_two  (peer_two),
        .xchg      (rx_valid),
        .fail      (train_fail),
        .mode_fast (mode_fast),
        .mode_two  (mode_two_lane),
        .done      (done),
        .give_up   (give_up)
    );

    // R2: reserved rate codes never produce a double-rate mode
    a_r2_reserved_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_msg[3]) |=> !mode_fast);
endmodule

// File: tb/lane_rate_negotiator_tb.sv
module lane_rate_negotiator_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       loc_fast_ok, loc_two_lane_ok, rx_valid, train_fail;
    logic [7:0] rx_msg, tx_msg;
    logic       mode_fast, mode_two_lane, done, give_up;

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    int  m_idx;      // 0 = 2-lane fast, 1 = 1-lane fast, 2 = 2-lane slow, 3 = 1-lane slow
    bit  m_cf, m_ct, m_done, m_give;

    always #5 clk = ~clk;

    lane_rate_negotiator u_dut (
        .clk(clk), .rst_n(rst_n), .loc_fast_ok(loc_fast_ok),
        .loc_two_lane_ok(loc_two_lane_ok), .rx_valid(rx_valid), .rx_msg(rx_msg),
        .train_fail(train_fail), .tx_msg(tx_msg), .mode_fast(mode_fast),
        .mode_two_lane(mode_two_lane), .done(done), .give_up(give_up)
    );

    function automatic bit idx_ok(int i, bit cf, bit ct);
        bit f = (i < 2);
        bit t = (i == 0) || (i == 2);
        return (!f || cf) && (!t || ct);
    endfunction

    function automatic int first_ok(int from, bit cf, bit ct);
        for (int i = from; i < 4; i++) if (idx_ok(i, cf, ct)) return i;
        return 3;
    endfunction

    function automatic logic [7:0] exp_tx(bit f, bit t);
        return {1'b0, t, 3'b000, f, 2'b00};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // compares all outputs with the model
    task automatic check_all(string tag);
        check(tag, {4'b0, mode_fast, mode_two_lane, done, give_up},
              {4'b0, m_done && m_idx < 2, m_done && (m_idx == 0 || m_idx == 2), m_done, m_give});
        check("R1 tx", tx_msg, exp_tx(loc_fast_ok, loc_two_lane_ok));
    endtask

    // applies the inputs for one cycle, updates the model, checks after the edge
    task automatic cycle(bit v, logic [7:0] m, bit f, string tag);
        bit pf, pt;
        rx_valid = v; rx_msg = m; train_fail = f;
        @(posedge clk);
        #1;
        pf = (m[3:2] == 2'b01);
        pt = m[6];
        if (v) begin
            m_cf = loc_fast_ok && pf; m_ct = loc_two_lane_ok && pt;
            m_idx = first_ok(0, m_cf, m_ct); m_done = 1; m_give = 0;
        end else if (f && m_done) begin
            if (m_idx == 3) m_give = 1;
            else m_idx = first_ok(m_idx + 1, m_cf, m_ct);
        end
        @(negedge clk);
        rx_valid = 0; train_fail = 0;
        check_all(tag);
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        rst_n = 0; loc_fast_ok = 1; loc_two_lane_ok = 1;
        rx_valid = 0; rx_msg = 0; train_fail = 0;
        m_idx = 3; m_cf = 0; m_ct = 0; m_done = 0; m_give = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check_all("R9 reset");
        // R8: failure before any exchange is ignored
        cycle(0, 8'h00, 1, "R8 fail before exchange");
        // R3 R4: full support both sides
        cycle(1, 8'h44, 0, "R3 R4 full");
        // R6: chain 2F -> 1F -> 2S -> 1S, then R7 give-up and hold
        cycle(0, 8'h00, 1, "R6 to 1F");
        cycle(0, 8'h00, 1, "R6 to 2S");
        cycle(0, 8'h00, 1, "R6 to 1S");
        cycle(0, 8'h00, 1, "R7 give up");
        cycle(0, 8'h00, 1, "R7 hold");
        cycle(0, 8'h00, 0, "R9 idle hold");
        // R5: new exchange clears give-up; R4 mixed pair, partner two-lane slow
        loc_two_lane_ok = 0;
        cycle(1, 8'h40, 0, "R4 R5 mixed pair");
        // R2: reserved rate codes with junk bits
        loc_two_lane_ok = 1;
        cycle(1, 8'hBB, 0, "R2 reserved 10");
        cycle(1, 8'h0C, 0, "R2 reserved 11");
        cycle(1, 8'hB7, 0, "R2 junk with 01");
        // R6 skip: 1F common, fail skips 2S
        cycle(1, 8'h04, 1, "R8 message wins over fail");
        cycle(0, 8'h00, 1, "R6 skip to 1S");
        // random
        for (int k = 0; k < 400; k++) begin
            int op = $urandom_range(0, 9);
            if (op == 0) begin
                loc_fast_ok = $urandom_range(0, 1);
                loc_two_lane_ok = $urandom_range(0, 1);
            end
            if (op < 3) cycle(1, 8'($urandom), $urandom_range(0, 1), "R3 R4 R5 random exchange");
            else if (op < 7) cycle(0, 8'($urandom), 1, "R6 R7 random fail");
            else cycle(0, 8'($urandom), 0, "R9 random idle");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule